// File: doc/BRIEF.md
# CDMA Chip Spreader, Interleaver and Block Formatter

This block builds the transmit chip blocks for one CDMA user. Each one-bit data symbol comes in with a Walsh-Hadamard code index and is multiplied chip by chip with that code of length NS. The NS chips of the symbol are placed into an interleaving matrix. A block collects M/NS symbols, which is M information chips. The matrix has NS rows and M/NS columns. It is filled one column per symbol and read out one row at a time. Because of this, the chips of one symbol come out evenly spaced across the block rather than next to each other. A known L-chip extension follows the M interleaved chips, which gives a block of P = M + L chips. One extra copy of the extension goes out ahead of the very first block, so that every block is preceded by an extension.

Two matrix banks work in ping-pong fashion: symbols fill one bank while the other bank is being read out. Symbols enter through a valid/ready pair. Chips leave as signed two-bit values with a valid flag and a start-of-block flag. A mode input selects an all-zero extension instead of the PN pattern. The receiver can use the same block to regenerate chip blocks from symbol decisions.

Top module: `cdma_chip_formatter`

## Requirements
- R1: Symbol bit 0 stands for +1 and bit 1 for -1. Chip m (0..NS-1) of code c is -1 when the parity of (c AND m) is odd, and +1 otherwise. An output information chip is the product of the code chip and the symbol value. Chip encoding: +1 = 2'b01, -1 = 2'b11, 0 = 2'b00.
- R2: Let COLS = (P-L)/NS, which is 15 by default. Chip m of the n-th symbol accepted into a block appears at offset m*COLS + n from that block's start-of-block chip.
- R3: Every block is P consecutive valid chips: M information chips, then L extension chips. blockStart is high on the first chip of a block and on no other chip.
- R4: With zeroPad low, extension chip k (k = 0 first) is -1 when bit k of PN_SEQ is 1 and +1 when that bit is 0.
- R5: With zeroPad high, every extension chip is 0 (2'b00).
- R6: After reset, exactly one L-chip extension is sent directly before the first block. No later block is preceded by an extra lead extension.
- R7: symReady is high while a matrix bank is free. After two full blocks of symbols are waiting, symReady goes low, and symbols offered while it is low are ignored and leave the output stream unchanged.
- R8: If the next block's symbols are complete before the current block's extension ends, the next block follows with no idle cycle between them. If they are not, chipValid goes low until they are.
- R9: During reset, chipValid and blockStart are low, chip is 2'b00 and symReady is high.
- R10: chip is never 2'b10, and it is 2'b00 whenever chipValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | A data symbol is offered |
| symBit | input | 1 | Symbol value, 0 = +1, 1 = -1 |
| codeSel | input | $clog2(NS) | Walsh-Hadamard code index for this symbol |
| zeroPad | input | 1 | Use all-zero extension instead of PN pattern |
| symReady | output | 1 | Symbol is accepted on this cycle when valid |
| chipValid | output | 1 | chip carries a chip |
| blockStart | output | 1 | First chip of a P-chip block |
| chip | output | 2 | Signed chip value |

## Verification
The bench builds the interleaved position of every chip from the code parity rule and compares each information chip in three blocks. A transposed matrix or an off-by-one column would put the chips of a symbol at the wrong stride. It checks that the lead extension appears exactly once, and that a later block entered after an idle gap starts straight away with blockStart and has no second lead. It offers extra symbols while both banks are full: a design that ignores symReady would overwrite a waiting block, and the corrupted chips would show up in the output. It also requires the second block to follow the first with no gap, and it checks that the tail turns to zeros in zero-pad mode.

// File: rtl/cdma_fmt_pkg.sv
package cdma_fmt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_INFO,
    PH_TAIL
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // write one symbol column
    logic wrBank;    // bank being filled
    logic rdBank;    // bank being read
    logic emitInfo;  // emit an information chip this cycle
    logic emitExt;   // emit an extension chip this cycle
    logic sob;       // first chip of a block
  } strobe_t;

  localparam logic [1:0] CHIP_POS  = 2'b01;
  localparam logic [1:0] CHIP_NEG  = 2'b11;
  localparam logic [1:0] CHIP_ZERO = 2'b00;

endpackage

// File: rtl/cdma_fmt_ctrl.sv
module cdma_fmt_ctrl
  import cdma_fmt_pkg::*;
#(
  parameter int BLK  = 256,
  parameter int EXT  = 16,
  parameter int COLS = 15,
  parameter int COLW = 4,
  parameter int POSW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            symValid,
  output logic            symReady,
  output strobe_t         strobe,
  output logic [POSW-1:0] pos,
  output logic [COLW-1:0] wrCol
);

  localparam int INFO = BLK - EXT;

  phase_e          phase;
  logic [1:0]      full;
  logic            wrBank;
  logic            rdBank;
  logic            leadDone;
  logic [POSW-1:0] posQ;
  logic [COLW-1:0] colQ;
  logic            accept;
  logic            colLast;
  logic            infoLast;
  logic            extLast;

  assign symReady = !full[wrBank];
  assign accept   = symValid && symReady;
  assign colLast  = (colQ == COLW'(COLS - 1));
  assign infoLast = (posQ == POSW'(INFO - 1));
  assign extLast  = (posQ == POSW'(EXT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      full     <= '0;
      wrBank   <= 1'b0;
      rdBank   <= 1'b0;
      leadDone <= 1'b0;
      posQ     <= '0;
      colQ     <= '0;
    end else begin
      if (accept) begin
        colQ <= colLast ? '0 : colQ + 1'b1;
        if (colLast) wrBank <= ~wrBank;
      end
      for (int b = 0; b < 2; b++) begin
        if (accept && colLast && (wrBank == 1'(b)))
          full[b] <= 1'b1;
        else if ((phase == PH_INFO) && infoLast && (rdBank == 1'(b)))
          full[b] <= 1'b0;
      end
      unique case (phase)
        PH_IDLE: if (full[rdBank]) begin
          posQ  <= '0;
          phase <= leadDone ? PH_INFO : PH_LEAD;
        end
        PH_LEAD: if (extLast) begin
          posQ     <= '0;
          phase    <= PH_INFO;
          leadDone <= 1'b1;
        end else posQ <= posQ + 1'b1;
        PH_INFO: if (infoLast) begin
          posQ   <= '0;
          phase  <= PH_TAIL;
          rdBank <= ~rdBank;
        end else posQ <= posQ + 1'b1;
        PH_TAIL: if (extLast) begin
          posQ  <= '0;
          phase <= full[rdBank] ? PH_INFO : PH_IDLE;
        end else posQ <= posQ + 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.wrEn     = accept;
    strobe.wrBank   = wrBank;
    strobe.rdBank   = rdBank;
    strobe.emitInfo = (phase == PH_INFO);
    strobe.emitExt  = (phase == PH_LEAD) || (phase == PH_TAIL);
    strobe.sob      = (phase == PH_INFO) && (posQ == '0);
  end

  assign pos   = posQ;
  assign wrCol = colQ;

endmodule

// File: rtl/cdma_fmt_dpath.sv
module cdma_fmt_dpath
  import cdma_fmt_pkg::*;
#(
  parameter int NS    = 16,
  parameter int INFO  = 240,
  parameter int EXT   = 16,
  parameter int COLS  = 15,
  parameter int CODEW = 4,
  parameter int COLW  = 4,
  parameter int POSW  = 8,
  parameter logic [EXT-1:0] PN_SEQ = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [POSW-1:0]  pos,
  input  logic [COLW-1:0]  wrCol,
  input  logic             symBit,
  input  logic [CODEW-1:0] codeSel,
  input  logic             zeroPad,
  output logic             chipValid,
  output logic             blockStart,
  output logic [1:0]       chip
);

  // Two banks of the NS x COLS matrix, one bit per chip (1 = -1)
  logic [2*INFO-1:0] store;
  logic [NS-1:0]     spreadBit;
  logic              infoBit;
  logic              extBit;

  // One spread chip per code position: data sign XOR code parity
  for (genvar m = 0; m < NS; m++) begin : g_spread
    assign spreadBit[m] = symBit ^ (^(codeSel & CODEW'(m)));
  end

  // Column write: chip m of this symbol goes to row m, column wrCol
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int m = 0; m < NS; m++)
        store[INFO * int'(strobe.wrBank) + m * COLS + int'(wrCol)] <= spreadBit[m];
    end
  end

  // Row-wise read is a linear walk over the bank
  assign infoBit = store[INFO * int'(strobe.rdBank) + int'(pos)];
  assign extBit  = PN_SEQ[int'(pos) % EXT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chipValid  <= 1'b0;
      blockStart <= 1'b0;
      chip       <= CHIP_ZERO;
    end else begin
      chipValid  <= strobe.emitInfo || strobe.emitExt;
      blockStart <= strobe.sob;
      if (strobe.emitInfo)
        chip <= infoBit ? CHIP_NEG : CHIP_POS;
      else if (strobe.emitExt)
        chip <= zeroPad ? CHIP_ZERO : (extBit ? CHIP_NEG : CHIP_POS);
      else
        chip <= CHIP_ZERO;
    end
  end

endmodule

// File: rtl/cdma_chip_formatter.sv
module cdma_chip_formatter
  import cdma_fmt_pkg::*;
#(
  parameter int NS  = 16,
  parameter int BLK = 256,
  parameter int EXT = 16,
  parameter logic [EXT-1:0] PN_SEQ = 16'hD5A3,
  localparam int CODEW = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             symValid,
  input  logic             symBit,
  input  logic [CODEW-1:0] codeSel,
  input  logic             zeroPad,
  output logic             symReady,
  output logic             chipValid,
  output logic             blockStart,
  output logic [1:0]       chip
);

  localparam int INFO = BLK - EXT;
  localparam int COLS = INFO / NS;
  localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int POSW = $clog2(BLK);

  strobe_t         strobe;
  logic [POSW-1:0] pos;
  logic [COLW-1:0] wrCol;

  cdma_fmt_ctrl #(
    .BLK(BLK), .EXT(EXT), .COLS(COLS), .COLW(COLW), .POSW(POSW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symReady(symReady),
    .strobe(strobe), .pos(pos), .wrCol(wrCol)
  );

  cdma_fmt_dpath #(
    .NS(NS), .INFO(INFO), .EXT(EXT), .COLS(COLS), .CODEW(CODEW),
    .COLW(COLW), .POSW(POSW), .PN_SEQ(PN_SEQ)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pos(pos), .wrCol(wrCol),
    .symBit(symBit), .codeSel(codeSel), .zeroPad(zeroPad),
    .chipValid(chipValid), .blockStart(blockStart), .chip(chip)
  );

endmodule

// File: rtl/cdma_fmt_checker.sv
module cdma_fmt_checker #(
  parameter int BLK = 256
) (
  input logic       clk,
  input logic       rstN,
  input logic       chipValid,
  input logic       blockStart,
  input logic [1:0] chip
);

  int   validCnt;
  logic seenSob;
  logic anyValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validCnt <= 0;
      seenSob  <= 1'b0;
      anyValid <= 1'b0;
    end else begin
      if (chipValid) begin
        anyValid <= 1'b1;
        validCnt <= blockStart ? 1 : validCnt + 1;
      end
      if (blockStart) seenSob <= 1'b1;
    end
  end

  p_sob_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |-> chipValid);

  p_block_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    (blockStart && seenSob) |-> (validCnt == BLK));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !chipValid |-> (chip == 2'b00));

  p_chip_code_r10: assert property (@(posedge clk) disable iff (!rstN)
    chipValid |-> (chip != 2'b10));

  p_lead_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    (chipValid && !anyValid) |-> !blockStart);

endmodule

bind cdma_chip_formatter cdma_fmt_checker #(.BLK(BLK)) i_chk (
  .clk(clk), .rstN(rstN), .chipValid(chipValid),
  .blockStart(blockStart), .chip(chip)
);

// File: tb/test_cdma_chip_formatter.sv
`timescale 1ns/1ps
module test_cdma_chip_formatter;

  localparam int NS = 16, BLK = 256, EXT = 16;
  localparam int INFO = BLK - EXT, COLS = INFO / NS;
  localparam logic [EXT-1:0] PN = 16'h4C1B;
  localparam int NA = EXT + 2 * BLK;

  // {code[3:0], bit}
  localparam logic [4:0] VEC [30] = '{
    5'h01, 5'h0E, 5'h13, 5'h1F, 5'h08, 5'h15, 5'h02, 5'h1B, 5'h0C, 5'h07,
    5'h10, 5'h19, 5'h04, 5'h1D, 5'h0A, 5'h11, 5'h06, 5'h1E, 5'h0B, 5'h14,
    5'h03, 5'h18, 5'h0D, 5'h16, 5'h09, 5'h1C, 5'h05, 5'h12, 5'h0F, 5'h1A
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic symValid = 1'b0, symBit = 1'b0, zeroPad = 1'b0;
  logic [3:0] codeSel = '0;
  logic symReady, chipValid, blockStart;
  logic [1:0] chip;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;
  logic [1:0] capChip [NA];
  logic       capSob  [NA];

  always #2.5 clk = ~clk;

  cdma_chip_formatter #(.NS(NS), .BLK(BLK), .EXT(EXT), .PN_SEQ(PN)) i_cdma_chip_formatter (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symBit(symBit),
    .codeSel(codeSel), .zeroPad(zeroPad), .symReady(symReady),
    .chipValid(chipValid), .blockStart(blockStart), .chip(chip)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] infoChip(input logic [3:0] code, input logic b, input int m);
    logic neg;
    neg = b ^ (^(code & 4'(m)));
    return neg ? 2'b11 : 2'b01;
  endfunction

  function automatic logic [1:0] extChip(input int k, input logic zp);
    if (zp) return 2'b00;
    return PN[k] ? 2'b11 : 2'b01;
  endfunction

  task automatic sendSym(input logic [3:0] code, input logic b);
    @(negedge clk);
    symValid = 1'b1; codeSel = code; symBit = b;
    while (!symReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic capture(input int n);
    @(negedge clk);
    while (!chipValid) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      check(chipValid, "R8 no gap inside stream", chipValid, 1);
      capChip[k] = chip;
      capSob[k]  = blockStart;
    end
  endtask

  task automatic checkBlock(input int base, input int blk, input logic zp, input bit inv);
    for (int t = 0; t < INFO; t++) begin
      int m, n;
      logic [4:0] v;
      logic b;
      m = t / COLS; n = t % COLS;
      v = VEC[blk * COLS + n];
      b = v[0];
      if (inv) begin v = VEC[n + COLS]; b = ~VEC[n][0]; end
      check(capChip[base + t] == infoChip(v[4:1], b, m), "R1/R2 info chip",
            capChip[base + t], infoChip(v[4:1], b, m));
      check(capSob[base + t] == (t == 0), "R3 blockStart position", capSob[base + t], t == 0);
    end
    for (int k = 0; k < EXT; k++) begin
      check(capChip[base + INFO + k] == extChip(k, zp), zp ? "R5 zero tail" : "R4 PN tail",
            capChip[base + INFO + k], extChip(k, zp));
      check(!capSob[base + INFO + k], "R3 no blockStart in tail", capSob[base + INFO + k], 0);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    if (!done) $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    check(!chipValid, "R9 reset chipValid", chipValid, 0);
    check(!blockStart, "R9 reset blockStart", blockStart, 0);
    check(chip == 2'b00, "R9 reset chip", chip, 0);
    check(symReady, "R9 reset symReady", symReady, 1);
    rstN = 1'b1;

    // Two blocks back to back, then symbols offered with both banks full
    fork
      begin
        for (int i = 0; i < 2 * COLS; i++) sendSym(VEC[i][4:1], VEC[i][0]);
        @(negedge clk);
        check(!symReady, "R7 ready low with both banks full", symReady, 0);
        symValid = 1'b1; codeSel = 4'hF; symBit = 1'b1;
        repeat (5) @(negedge clk);
        symValid = 1'b0;
      end
      capture(NA);
    join

    for (int k = 0; k < EXT; k++) begin
      check(capChip[k] == extChip(k, 1'b0), "R6 lead extension", capChip[k], extChip(k, 1'b0));
      check(!capSob[k], "R6 no blockStart in lead", capSob[k], 0);
    end
    checkBlock(EXT, 0, 1'b0, 1'b0);
    checkBlock(EXT + BLK, 1, 1'b0, 1'b0);

    @(negedge clk);
    check(!chipValid, "R8 idle when no block ready", chipValid, 0);
    check(chip == 2'b00, "R10 idle chip zero", chip, 0);

    // Zero-pad block after an idle gap: no second lead
    zeroPad = 1'b1;
    repeat (10) @(negedge clk);
    check(!chipValid, "R8 stays idle", chipValid, 0);
    fork
      begin
        for (int i = 0; i < COLS; i++) sendSym(VEC[i + COLS][4:1], ~VEC[i][0]);
        @(negedge clk);
        symValid = 1'b0;
      end
      capture(BLK);
    join
    check(capSob[0], "R6 later block has no lead", capSob[0], 1);
    checkBlock(0, 0, 1'b1, 1'b1);

    repeat (3) @(negedge clk);
    check(!chipValid && chip == 2'b00, "R10 idle after zero-pad block", chip, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule